// File: doc/BRIEF.md
# In-System Programming Status Pins and Security Gate

This block sits between the instruction decoder of a JTAG test access port and the engine that programs the on-chip flash. It takes decoded in-system configuration commands and turns them into two things. The first is a pair of fast status pins: a ready pin that follows the flash engine, and a sticky fault pin that reports failed program or erase cycles. A programmer can poll these pins directly, so it does not have to shift status out through the scan chain. The second is a set of one-cycle permit pulses that tell the flash engine which operation it may start.

The pins stay released until a session is opened with an enable command. That same command chooses between push-pull drive and open-drain drive. Open-drain drive lets the pins of several chained devices share one wired-OR net.

While the device is secured, every operation that reads or changes flash contents is refused, except full chip erase. When a full chip erase completes, the device becomes unsecured.

The JTAG port is live in one of two cases:
- a configuration bit dedicates the port; or
- software sets bit 0 of a small enable register.

If the port is dedicated, a chip reset does not end an open session. If the port is enabled only through the register, a chip reset ends the session.

Top module: `isc_status_gate`

## Requirements
- R1: The enable register stores only bit 0 of the written byte. It reads back as {7'b0, bit0} and resets to 0x00.
- R2: Both pins are released (output enable 0, output value 1) until an enable command (code 1) is accepted. A disable command (code 2) releases them again.
- R3: In push-pull mode the ready pin is driven high when neither the flash-busy input nor the secondary-write-busy input is set. Otherwise it is driven low. It updates one clock after the inputs.
- R4: A flash error input during an open session drives the fault pin low. The pin stays low until a clear command (code 3), a disable command or a reset.
- R5: When a flash error and a clear command arrive in the same cycle, the error wins and the fault pin stays low.
- R6: The open-drain select input is latched when an enable command is accepted. In open-drain mode a pin is never driven high: its output value is 0 and its output enable equals the inverse of its level. The mode holds until the next enable or disable command.
- R7: While secured, program (code 4), sector erase (5), verify (6) and read (7) each give a one-cycle reject pulse and no permit. They leave the fault pin unchanged.
- R8: While unsecured, each of codes 4 to 7 gives a one-cycle pulse on bit (code-4) of the permit vector. Full chip erase (code 8) gives its own permit pulse, whether or not the device is secured.
- R9: The secured flag is loaded from the security configuration input at reset. It is cleared by the chip-erase-done input.
- R10: Reset with the port dedicated keeps the session open and the pins driven, but clears the fault. Reset without the port dedicated ends the session.
- R11: When the port is neither dedicated nor enabled by the register, every command is ignored.
- R12: Operation commands (codes 4 to 8) that arrive while no session is open are ignored: no permit and no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high chip reset |
| port_dedicated | input | 1 | Configuration bit that dedicates the JTAG pins |
| sec_cfg | input | 1 | Stored security bit, loaded at reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_code | input | 4 | Decoded command code |
| cmd_od | input | 1 | Open-drain select, sampled with an enable command |
| flash_busy | input | 1 | Program or erase cycle in progress |
| sec_wr_busy | input | 1 | Secondary flash write in progress |
| flash_err | input | 1 | Program or erase failure pulse |
| chip_erase_done | input | 1 | Full chip erase finished |
| rdy_o | output | 1 | Ready pin output value |
| rdy_oe | output | 1 | Ready pin output enable |
| flt_o | output | 1 | Fault pin output value |
| flt_oe | output | 1 | Fault pin output enable |
| permit_o | output | 4 | Permit pulses: program, sector erase, verify, read |
| permit_chip_o | output | 1 | Full chip erase permit pulse |
| reject_o | output | 1 | Blocked command pulse |
| secured_o | output | 1 | Current secured flag |

## Verification
The hardest state to reach is a chip reset that arrives while a session is open on a dedicated port with a fault pending. The session must survive the reset while the fault clears, and a second reset without the dedicated bit must end the session. The bench opens a session, raises a fault, then pulses reset under each setting of the dedicated bit, and checks the pins and the register readback right after each reset. The security gate is swept across every operation code, both secured and unsecured. The ready pin is swept across all busy-input combinations in both drive modes.

// File: rtl/isc_gate_pkg.sv
package isc_gate_pkg;
  localparam int CODE_W = 4;
  localparam int N_OPS  = 4;

  typedef enum logic [CODE_W-1:0] {
    CMD_NOP        = 4'd0,
    CMD_ENABLE     = 4'd1,
    CMD_DISABLE    = 4'd2,
    CMD_CLEAR      = 4'd3,
    CMD_PROGRAM    = 4'd4,
    CMD_ERASE      = 4'd5,
    CMD_VERIFY     = 4'd6,
    CMD_READ       = 4'd7,
    CMD_CHIP_ERASE = 4'd8
  } cmd_e;

  localparam logic [CODE_W-1:0] OP_BASE = CMD_PROGRAM;
endpackage

// File: rtl/isc_enable_reg.sv
module isc_enable_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'(1);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata & KEEP_MASK;
  end
endmodule

// File: rtl/isc_session.sv
module isc_session
  import isc_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dedicated,
  input  logic              port_on,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  input  logic              od_sel,
  input  logic              flash_err,
  input  logic              erase_done,
  input  logic              sec_cfg,
  output logic              active_q,
  output logic              od_q,
  output logic              err_q,
  output logic              sec_q,
  output logic              active_d,
  output logic              od_d,
  output logic              err_d
);
  cmd_e cmd;
  logic is_en, is_dis, is_clr, hard_rst;
  logic sec_d;

  assign cmd      = cmd_e'(code);
  assign is_en    = accept && (cmd == CMD_ENABLE);
  assign is_dis   = accept && (cmd == CMD_DISABLE);
  assign is_clr   = accept && (cmd == CMD_CLEAR);
  assign hard_rst = rst && !dedicated;

  always_comb begin
    if (hard_rst || !port_on) active_d = 1'b0;
    else if (is_en)           active_d = 1'b1;
    else if (is_dis)          active_d = 1'b0;
    else                      active_d = active_q;
  end

  always_comb begin
    if (hard_rst || is_dis) od_d = 1'b0;
    else if (is_en)         od_d = od_sel;
    else                    od_d = od_q;
  end

  // Session end and reset dominate; an error beats a same-cycle clear.
  always_comb begin
    if (rst || !active_d)           err_d = 1'b0;
    else if (active_q && flash_err) err_d = 1'b1;
    else if (is_clr)                err_d = 1'b0;
    else                            err_d = err_q;
  end

  always_comb begin
    if (rst)             sec_d = sec_cfg;
    else if (erase_done) sec_d = 1'b0;
    else                 sec_d = sec_q;
  end

  always_ff @(posedge clk) begin
    active_q <= active_d;
    od_q     <= od_d;
    err_q    <= err_d;
    sec_q    <= sec_d;
  end
endmodule

// File: rtl/isc_permit.sv
module isc_permit
  import isc_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              active_q,
  input  logic              sec_q,
  input  logic [CODE_W-1:0] code,
  output logic [N_OPS-1:0]  permit_o,
  output logic              chip_o,
  output logic              reject_o
);
  logic             live;
  logic [N_OPS-1:0] hit;

  assign live = accept && active_q;

  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    assign hit[i] = live && (code == OP_BASE + CODE_W'(i));
    always_ff @(posedge clk) begin
      if (rst && !active_q) permit_o[i] <= 1'b0;
      else                  permit_o[i] <= hit[i] && !sec_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && !active_q) begin
      chip_o   <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      chip_o   <= live && (cmd_e'(code) == CMD_CHIP_ERASE);
      reject_o <= (|hit) && sec_q;
    end
  end
endmodule

// File: rtl/isc_pin_drv.sv
module isc_pin_drv (
  input  logic clk,
  input  logic active_d,
  input  logic od_d,
  input  logic level_d,
  output logic pin_o,
  output logic pin_oe
);
  always_ff @(posedge clk) begin
    if (!active_d) begin
      pin_o  <= 1'b1;
      pin_oe <= 1'b0;
    end else if (od_d) begin
      pin_o  <= 1'b0;
      pin_oe <= !level_d;
    end else begin
      pin_o  <= level_d;
      pin_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/isc_status_gate.sv
module isc_status_gate
  import isc_gate_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_dedicated,
  input  logic              sec_cfg,
  input  logic              en_wr,
  input  logic [REG_W-1:0]  en_wdata,
  output logic [REG_W-1:0]  en_rdata,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_od,
  input  logic              flash_busy,
  input  logic              sec_wr_busy,
  input  logic              flash_err,
  input  logic              chip_erase_done,
  output logic              rdy_o,
  output logic              rdy_oe,
  output logic              flt_o,
  output logic              flt_oe,
  output logic [N_OPS-1:0]  permit_o,
  output logic              permit_chip_o,
  output logic              reject_o,
  output logic              secured_o
);
  localparam int N_PINS = 2;

  logic [REG_W-1:0] en_q;
  logic port_on, accept;
  logic active_q, od_q, err_q, sec_q;
  logic active_d, od_d, err_d;
  logic [N_PINS-1:0] lvl, pin_v, pin_e;

  isc_enable_reg #(.REG_W(REG_W)) u_enreg (
    .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata), .q(en_q)
  );

  assign en_rdata = en_q;
  assign port_on  = port_dedicated || en_q[0];
  assign accept   = cmd_valid && port_on && !(rst && !port_dedicated);

  isc_session u_sess (
    .clk(clk), .rst(rst), .dedicated(port_dedicated), .port_on(port_on),
    .accept(accept), .code(cmd_code), .od_sel(cmd_od),
    .flash_err(flash_err), .erase_done(chip_erase_done), .sec_cfg(sec_cfg),
    .active_q(active_q), .od_q(od_q), .err_q(err_q), .sec_q(sec_q),
    .active_d(active_d), .od_d(od_d), .err_d(err_d)
  );

  isc_permit u_perm (
    .clk(clk), .rst(rst), .accept(accept), .active_q(active_q),
    .sec_q(sec_q), .code(cmd_code), .permit_o(permit_o),
    .chip_o(permit_chip_o), .reject_o(reject_o)
  );

  assign lvl[0] = !(flash_busy || sec_wr_busy);
  assign lvl[1] = !err_d;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    isc_pin_drv u_drv (
      .clk(clk), .active_d(active_d), .od_d(od_d), .level_d(lvl[p]),
      .pin_o(pin_v[p]), .pin_oe(pin_e[p])
    );
  end

  assign rdy_o     = pin_v[0];
  assign rdy_oe    = pin_e[0];
  assign flt_o     = pin_v[1];
  assign flt_oe    = pin_e[1];
  assign secured_o = sec_q;
endmodule

// File: rtl/isc_gate_chk.sv
module isc_gate_chk
  import isc_gate_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [CODE_W-1:0] cmd_code,
  input logic              en_wr,
  input logic              port_on,
  input logic              active_q,
  input logic              od_q,
  input logic              sec_q,
  input logic              rdy_o,
  input logic              rdy_oe,
  input logic              flt_o,
  input logic              flt_oe,
  input logic [N_OPS-1:0]  permit_o,
  input logic              permit_chip_o,
  input logic              reject_o
);
  logic flt_low, ends_err, is_op;
  assign flt_low  = flt_oe && !flt_o;
  assign ends_err = cmd_valid && (cmd_code == CMD_CLEAR || cmd_code == CMD_DISABLE);
  assign is_op    = cmd_valid && cmd_code >= CMD_PROGRAM && cmd_code <= CMD_READ;

  AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (!rdy_oe && !flt_oe)); // R2

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flt_low && !ends_err && !en_wr) |=> flt_low); // R4

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (active_q && od_q) |-> ((rdy_oe -> !rdy_o) && (flt_oe -> !flt_o))); // R6

  AST_SECURE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (port_on && active_q && sec_q && is_op) |=> (reject_o && permit_o == '0)); // R7

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({permit_o, permit_chip_o, reject_o})); // R8

  AST_NO_PORT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !port_on |=> (permit_o == '0 && !permit_chip_o && !reject_o)); // R11
endmodule

bind isc_status_gate isc_gate_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .en_wr(en_wr), .port_on(port_on), .active_q(active_q), .od_q(od_q),
  .sec_q(sec_q), .rdy_o(rdy_o), .rdy_oe(rdy_oe), .flt_o(flt_o),
  .flt_oe(flt_oe), .permit_o(permit_o), .permit_chip_o(permit_chip_o),
  .reject_o(reject_o)
);

// File: tb/isc_status_gate_tb.sv
`timescale 1ns/1ps
module isc_status_gate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_dedicated = 1'b0, sec_cfg = 1'b0, en_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata;
  logic cmd_valid = 1'b0, cmd_od = 1'b0;
  logic [3:0] cmd_code = '0;
  logic flash_busy = 1'b0, sec_wr_busy = 1'b0, flash_err = 1'b0, chip_erase_done = 1'b0;
  logic rdy_o, rdy_oe, flt_o, flt_oe, permit_chip_o, reject_o, secured_o;
  logic [3:0] permit_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  isc_status_gate u_dut (.*);

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmd(int c, logic od = 1'b0);
    cmd_valid = 1'b1; cmd_code = 4'(c); cmd_od = od;
    tick();
    cmd_valid = 1'b0; cmd_code = '0; cmd_od = 1'b0;
  endtask

  task automatic wr_en(logic [7:0] d);
    en_wr = 1'b1; en_wdata = d;
    tick();
    en_wr = 1'b0;
  endtask

  task automatic pins(string req, logic ro, logic re, logic fo, logic fe);
    chk(req, {rdy_o, rdy_oe, flt_o, flt_oe}, {ro, re, fo, fe});
  endtask

  task automatic pulses(string req, logic [3:0] p, logic c, logic r);
    chk(req, {permit_o, permit_chip_o, reject_o}, {p, c, r});
  endtask

  initial begin
    tick(); tick();
    pins("R2 reset pins", 1, 0, 1, 0);
    chk("R1 reset reg", en_rdata, 8'h00);
    pulses("R8 reset pulses", 0, 0, 0);
    rst = 1'b0; tick();

    // R11: port off, enable and ops ignored
    cmd(1); pins("R11 enable ignored", 1, 0, 1, 0);
    cmd(4); pulses("R11 op ignored", 0, 0, 0);

    // R1 register sweep
    for (int v = 0; v < 256; v += 51) begin
      wr_en(8'(v)); chk("R1 readback", en_rdata, {7'b0, 1'(v & 1)});
    end
    wr_en(8'hFF); chk("R1 write FF", en_rdata, 8'h01);

    // R12: ops before session
    for (int c = 4; c <= 8; c++) begin
      cmd(c); pulses("R12 no session", 0, 0, 0);
    end

    // R2/R3 push-pull session
    cmd(1, 1'b0);
    pins("R2 enabled", 1, 1, 1, 1);
    for (int b = 0; b < 4; b++) begin
      flash_busy = b[0]; sec_wr_busy = b[1];
      tick();
      pins("R3 ready level", (b == 0), 1, 1, 1);
    end
    flash_busy = 0; sec_wr_busy = 0; tick();

    // R8 unsecured permits
    for (int c = 4; c <= 7; c++) begin
      cmd(c); pulses("R8 permit", 4'(1 << (c - 4)), 0, 0);
      tick(); pulses("R8 one cycle", 0, 0, 0);
    end
    cmd(8); pulses("R8 chip permit", 0, 1, 0);

    // R4 sticky fault
    flash_err = 1; tick(); flash_err = 0;
    pins("R4 fault low", 1, 1, 0, 1);
    tick(); tick(); tick();
    pins("R4 fault held", 1, 1, 0, 1);
    cmd(3); pins("R4 clear", 1, 1, 1, 1);

    // R5 error beats clear
    flash_err = 1; cmd(3); flash_err = 0;
    pins("R5 error wins", 1, 1, 0, 1);
    cmd(3); pins("R5 later clear", 1, 1, 1, 1);

    // R6 open-drain
    cmd(1, 1'b1);
    for (int b = 0; b < 4; b++) begin
      flash_busy = b[0]; sec_wr_busy = b[1];
      tick();
      pins("R6 od ready", 0, (b != 0), 0, 0);
    end
    flash_busy = 0; sec_wr_busy = 0;
    flash_err = 1; tick(); flash_err = 0;
    pins("R6 od fault", 0, 0, 0, 1);
    cmd(4, 1'b0); pins("R6 od latched", 0, 0, 0, 1);
    cmd(2); pins("R2 disable", 1, 0, 1, 0);
    cmd(1, 1'b0); pins("R4 disable cleared fault", 1, 1, 1, 1);

    // R10 dedicated reset keeps session, clears fault
    port_dedicated = 1;
    flash_err = 1; tick(); flash_err = 0;
    rst = 1; tick(); rst = 0;
    pins("R10 dedicated reset", 1, 1, 1, 1);
    chk("R1 reset clears reg", en_rdata, 8'h00);
    port_dedicated = 0; tick();
    pins("R11 port off ends session", 1, 0, 1, 0);

    // R7/R9 secured
    sec_cfg = 1; rst = 1; tick(); rst = 0; sec_cfg = 0;
    chk("R9 secured loaded", secured_o, 1);
    pins("R10 reset ends session", 1, 0, 1, 0);
    wr_en(8'h01); cmd(1);
    for (int c = 4; c <= 7; c++) begin
      cmd(c); pulses("R7 blocked", 0, 0, 1);
      pins("R7 no fault", 1, 1, 1, 1);
    end
    cmd(8); pulses("R8 chip while secured", 0, 1, 0);
    chip_erase_done = 1; tick(); chip_erase_done = 0;
    chk("R9 cleared", secured_o, 0);
    cmd(4); pulses("R9 program allowed", 4'b0001, 0, 0);

    finish_run();
  end
endmodule